// File: doc/BRIEF.md
# Masked Bit Test and Skip Unit

This unit resolves the conditional-skip instructions of a small nibble-wide controller and owns the flag state those instructions read and write. Each cycle it receives an operation code, a data nibble fetched from memory, a bit-select mask and the index of one status register. It keeps a small bank of 4-bit status registers and a vector of sticky unlock flags.

Test operations compare the selected bits against an all-ones or all-zeros rule. When the rule holds, the unit raises `skip_o` for one cycle, and the fetch stage then drops the next instruction. Set and reset operations change only the status bits that the mask selects.

The sources that raise unlock flags are modelled as plain input pulses, one per flag. The unit does not address memory, fetch instructions or perform ALU work.

Top module: `bit_test_skip_unit`

## Requirements
- R1: Operation code 1 (memory-true) requests a skip when every bit of `mem_i` selected by `mask_i` is 1.
- R2: Operation code 2 (memory-false) requests a skip when every bit of `mem_i` selected by `mask_i` is 0.
- R3: Operation code 3 (status-set) drives to 1 the bits of status register `sel_i` that `mask_i` selects. All other bits and registers keep their value.
- R4: Operation code 4 (status-reset) drives to 0 the bits of status register `sel_i` that `mask_i` selects. All other bits and registers keep their value.
- R5: Operation code 5 (status-true) skips when the masked bits of status register `sel_i` are all 1. Operation code 6 (status-false) skips when those bits are all 0.
- R6: Operation code 7 (unlock test) skips when every unlock flag selected by `mask_i` is 0, meaning no event has been recorded on those flags.
- R7: For any test code (1, 2, 5, 6, 7), a mask of 0000 selects no bits, so a skip is requested.
- R8: Bit k of `unl_set_i` raises unlock flag k, and the flag then holds until `unl_clr_i` or reset. `unl_clr_i` clears all flags. When a set and a clear arrive in the same cycle, the set wins for that flag.
- R9: `skip_o` is a registered output. It is asserted during the cycle after a test whose rule holds, for exactly one cycle. Codes 0, 3 and 4 never produce a skip.
- R10: Synchronous reset clears all status registers, all unlock flags and `skip_o`.
- R11: A test evaluates the state as it stood before the current cycle. It does not see an unlock pulse or a status update that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code |
| mem_i | input | NIB | Memory data nibble |
| mask_i | input | NIB | Bit-select mask |
| sel_i | input | SW | Status register index |
| unl_set_i | input | NIB | Unlock event pulses, one per flag |
| unl_clr_i | input | 1 | Clear all unlock flags |
| skip_o | output | 1 | Skip request for the next instruction |

## Verification
Two kinds of same-cycle collision are possible:
- **Unlock flags:** an event pulse can coincide with an unlock test, and it can also coincide with a clear.
- **Status registers:** a status write is followed at once by a test of the same register.

The bench provokes these collisions in two ways. Directed sequences place a pulse in the same cycle as a test and a clear. Random traffic keeps pulses sparse and draws its register index from a small set, so a test often reads a register that was just written.

Each skip is judged against a model that evaluates the test on the state from before the cycle and only then applies the cycle's updates. Set takes priority over clear in that model.

// File: rtl/bit_test_skip_unit.sv
module bit_test_skip_unit #(
  parameter int NIB   = 4,
  parameter int NSTAT = 4,
  localparam int SW   = (NSTAT > 1) ? $clog2(NSTAT) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     op_i,
  input  logic [NIB-1:0] mem_i,
  input  logic [NIB-1:0] mask_i,
  input  logic [SW-1:0]  sel_i,
  input  logic [NIB-1:0] unl_set_i,
  input  logic           unl_clr_i,
  output logic           skip_o
);

  localparam logic [2:0] OP_NOP  = 3'd0;
  localparam logic [2:0] OP_MT   = 3'd1;
  localparam logic [2:0] OP_MF   = 3'd2;
  localparam logic [2:0] OP_SSET = 3'd3;
  localparam logic [2:0] OP_SCLR = 3'd4;
  localparam logic [2:0] OP_ST   = 3'd5;
  localparam logic [2:0] OP_SF   = 3'd6;
  localparam logic [2:0] OP_UT   = 3'd7;

  logic [NIB-1:0] stat_q [NSTAT];
  logic [NIB-1:0] unl_q;
  logic [NIB-1:0] stat_sel, mem_m, stat_m, unl_m;
  logic           hit;

  assign stat_sel = stat_q[sel_i];
  assign mem_m    = mem_i & mask_i;
  assign stat_m   = stat_sel & mask_i;
  assign unl_m    = unl_q & mask_i;

  always_comb begin
    case (op_i)
      OP_MT:   hit = (mem_m == mask_i);
      OP_MF:   hit = (mem_m == '0);
      OP_ST:   hit = (stat_m == mask_i);
      OP_SF:   hit = (stat_m == '0);
      OP_UT:   hit = (unl_m == '0);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTAT; i++) stat_q[i] <= '0;
    end else if (op_i == OP_SSET) begin
      stat_q[sel_i] <= stat_sel | mask_i;
    end else if (op_i == OP_SCLR) begin
      stat_q[sel_i] <= stat_sel & ~mask_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) unl_q <= '0;
    else     unl_q <= (unl_q & ~{NIB{unl_clr_i}}) | unl_set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) skip_o <= 1'b0;
    else     skip_o <= hit;
  end

  AST_MEM_TRUE: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MT && (mem_i & mask_i) == mask_i) |=> skip_o); // R1
  AST_MEM_FALSE: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_MF && (mem_i & mask_i) == '0) |=> skip_o); // R2
  AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SSET) |=> ((stat_q[$past(sel_i)] & $past(mask_i)) == $past(mask_i))); // R3
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SCLR) |=> ((stat_q[$past(sel_i)] & $past(mask_i)) == '0)); // R4
  AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0 && op_i != OP_NOP && op_i != OP_SSET && op_i != OP_SCLR) |=> skip_o); // R7
  AST_UNL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (unl_set_i != '0) |=> ((unl_q & $past(unl_set_i)) == $past(unl_set_i))); // R8
  AST_UNL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (unl_clr_i && unl_set_i == '0) |=> (unl_q == '0)); // R8
  AST_NO_SKIP_NONTEST: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_NOP || op_i == OP_SSET || op_i == OP_SCLR) |=> !skip_o); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!skip_o && unl_q == '0)); // R10

endmodule

// File: tb/bit_test_skip_unit_tb.sv
module bit_test_skip_unit_tb;
  localparam int NIB = 4, NSTAT = 4, SW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] op_i = '0;
  logic [NIB-1:0] mem_i = '0, mask_i = '0, unl_set_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic unl_clr_i = 1'b0;
  logic skip_o;

  int n_chk = 0, n_bad = 0;
  logic [NIB-1:0] m_stat [NSTAT];
  logic [NIB-1:0] m_unl;

  bit_test_skip_unit #(.NIB(NIB), .NSTAT(NSTAT)) u_dut (
    .clk, .rst, .op_i, .mem_i, .mask_i, .sel_i, .unl_set_i, .unl_clr_i, .skip_o);

  always #4 clk = ~clk;

  function automatic logic exp_skip(input logic [2:0] op, input logic [NIB-1:0] mem,
                                    input logic [NIB-1:0] msk, input logic [SW-1:0] sel);
    case (op)
      3'd1: return (mem & msk) == msk;
      3'd2: return (mem & msk) == 0;
      3'd5: return (m_stat[sel] & msk) == msk;
      3'd6: return (m_stat[sel] & msk) == 0;
      3'd7: return (m_unl & msk) == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op, input logic [NIB-1:0] msk);
    if (msk == 0 && op inside {3'd1, 3'd2, 3'd5, 3'd6, 3'd7}) return "R7";
    case (op)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3/R9";
      3'd4: return "R4/R9";
      3'd5, 3'd6: return "R5";
      3'd7: return "R6/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: skip_o=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [NIB-1:0] mem, input logic [NIB-1:0] msk,
                      input logic [SW-1:0] sel, input logic [NIB-1:0] st, input logic clr,
                      input string req);
    logic e;
    op_i = op; mem_i = mem; mask_i = msk; sel_i = sel; unl_set_i = st; unl_clr_i = clr;
    e = exp_skip(op, mem, msk, sel);
    if (op == 3'd3) m_stat[sel] = m_stat[sel] | msk;
    if (op == 3'd4) m_stat[sel] = m_stat[sel] & ~msk;
    m_unl = (clr ? '0 : m_unl) | st;
    @(posedge clk);
    @(negedge clk);
    op_i = '0; unl_set_i = '0; unl_clr_i = 1'b0;
    check(skip_o, e, (req == "") ? tag(op, msk) : req);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NSTAT; i++) m_stat[i] = '0;
    m_unl = '0;
    repeat (3) @(negedge clk);
    check(skip_o, 1'b0, "R10 reset skip");
    rst = 1'b0;
    step(3'd6, 4'h0, 4'hF, 2'd0, 4'h0, 1'b0, "R10 stat0 zero");
    step(3'd6, 4'h0, 4'hF, 2'd3, 4'h0, 1'b0, "R10 stat3 zero");
    step(3'd7, 4'h0, 4'hF, 2'd0, 4'h0, 1'b0, "R10 unlock zero");
    step(3'd1, 4'h5, 4'h5, 2'd0, 4'h0, 1'b0, "R1 match");
    step(3'd1, 4'h4, 4'h5, 2'd0, 4'h0, 1'b0, "R1 miss");
    step(3'd2, 4'hA, 4'h5, 2'd0, 4'h0, 1'b0, "R2 match");
    step(3'd2, 4'hB, 4'h5, 2'd0, 4'h0, 1'b0, "R2 miss");
    step(3'd3, 4'h0, 4'h6, 2'd1, 4'h0, 1'b0, "R3 set");
    step(3'd5, 4'h0, 4'h6, 2'd1, 4'h0, 1'b0, "R3 bits set");
    step(3'd6, 4'h0, 4'h9, 2'd1, 4'h0, 1'b0, "R3 others kept");
    step(3'd4, 4'h0, 4'h2, 2'd1, 4'h0, 1'b0, "R4 clr");
    step(3'd5, 4'h0, 4'h4, 2'd1, 4'h0, 1'b0, "R4 others kept");
    step(3'd6, 4'h0, 4'h2, 2'd1, 4'h0, 1'b0, "R4 bit cleared");
    step(3'd7, 4'h0, 4'h0, 2'd0, 4'h0, 1'b0, "R7 mask0 unlock");
    step(3'd1, 4'h0, 4'h0, 2'd0, 4'h0, 1'b0, "R7 mask0 memtrue");
    step(3'd7, 4'h0, 4'h2, 2'd0, 4'h2, 1'b0, "R11 same-cycle pulse unseen");
    step(3'd7, 4'h0, 4'h2, 2'd0, 4'h0, 1'b0, "R8 flag now set");
    step(3'd7, 4'h0, 4'hD, 2'd0, 4'h0, 1'b0, "R6 other flags clear");
    step(3'd0, 4'h0, 4'h0, 2'd0, 4'h1, 1'b1, "R8 set beats clr");
    step(3'd7, 4'h0, 4'h1, 2'd0, 4'h0, 1'b0, "R8 set survived");
    step(3'd7, 4'h0, 4'h2, 2'd0, 4'h0, 1'b0, "R8 other cleared");
    step(3'd3, 4'h0, 4'h0, 2'd0, 4'h0, 1'b0, "R9 set no skip");
    step(3'd4, 4'h0, 4'h0, 2'd0, 4'h0, 1'b0, "R9 clr no skip");
    step(3'd0, 4'h0, 4'h0, 2'd0, 4'h0, 1'b0, "R9 one-cycle pulse");
    for (int k = 0; k < 4000; k++) begin
      logic [NIB-1:0] st;
      st = ($urandom_range(0, 9) == 0) ? NIB'($urandom) : '0;
      step(3'($urandom), NIB'($urandom), NIB'($urandom), SW'($urandom_range(0, 1)),
           st, ($urandom_range(0, 14) == 0), "");
    end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NSTAT; i++) m_stat[i] = '0;
    m_unl = '0;
    check(skip_o, 1'b0, "R10 reset again");
    rst = 1'b0;
    step(3'd7, 4'h0, 4'hF, 2'd0, 4'h0, 1'b0, "R10 unlock cleared");
    step(3'd6, 4'h0, 4'hF, 2'd0, 4'h0, 1'b0, "R10 stat cleared");
    step(3'd6, 4'h0, 4'hF, 2'd1, 4'h0, 1'b0, "R10 stat1 cleared");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule